// File: doc/BRIEF.md
# Display RAM Access Controller

This block connects a host command/data port to a display memory of 132 columns by 65 lines. The memory is organised as eight full pages of eight lines each plus a ninth page that holds a single line. The controller keeps a page register and a column counter, and it drives the memory address, write enable and write data. It returns read data through a one-entry holding register, so each read delivers the value fetched by the read before it. Each host byte lies vertically in a page: bit 0 is the top line of that page and bit 7 is the bottom line.

The host side arrives as decoded, single-cycle strobes. These are a page set, two column nibble loads (high and low), a data write and a data read, plus a level input that picks the direction of the column-to-segment mapping. The memory is external and is read combinationally: its read data must be valid in the same cycle as the address the block presents. The block also outputs the segment index that the current column drives, so the direction setting can be seen at the ports.

Top module: `dispram_access`

## Requirements
- R1: After reset the page register, the column counter, the holding register and the read-data output are all zero, and the memory write enable is low.
- R2: A page-set strobe with a code of 0 to 8 loads that page. A code above 8 leaves the page unchanged. The page never changes without a page-set strobe.
- R3: A high-nibble load replaces column bits 7:4 and a low-nibble load replaces bits 3:0. A merged value above 83h is clamped to 83h.
- R4: A write strobe raises the write enable in the same cycle, at the current page and column, with the host byte as write data. The column then advances by one.
- R5: A read strobe presents the holding register on the read-data output from the next cycle. It loads the holding register from the memory at the current address and advances the column by one.
- R6: The holding register is not changed by address loads or writes, so the first read after either returns the stale held value. The read-data output changes only on a read.
- R7: At column 83h a read or write leaves the column at 83h. The column never wraps and never carries into the page.
- R8: On page 8, write data bits 7:1 are forced to zero, and a read loads zeros into holding-register bits 7:1 whatever the memory returns.
- R9: The segment-index output equals the column when the direction input is 0, and 83h minus the column when it is 1.
- R10: At most one action takes effect per cycle, by priority: page set, high nibble, low nibble, write, read. An invalid page code still blocks every lower action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| setPageStb | input | 1 | Page-set strobe |
| pageIn | input | 4 | Page code for the page-set strobe |
| setColHiStb | input | 1 | Column high-nibble load strobe |
| setColLoStb | input | 1 | Column low-nibble load strobe |
| nibbleIn | input | 4 | Nibble value for the column loads |
| wrStb | input | 1 | Display-data write strobe |
| rdStb | input | 1 | Display-data read strobe |
| hostDataIn | input | 8 | Host write byte |
| adcRev | input | 1 | Column-to-segment direction, 1 = reversed |
| ramPage | output | 4 | Memory page address (current page) |
| ramCol | output | 8 | Memory column address (current column) |
| ramWrEn | output | 1 | Memory write enable |
| ramWrData | output | 8 | Memory write data, masked on page 8 |
| ramRdData | input | 8 | Memory read data, combinational on the address |
| rdData | output | 8 | Read-back byte for the host |
| segIdx | output | 8 | Segment index driven by the current column |

## Verification
The properties take the strobes as synchronous levels sampled on the rising edge. They allow strobes to overlap, because each property spells out the priority it depends on. They also assume that the memory read data settles within the cycle, and that no strobe is meant to act while reset is low. The stimulus changes inputs only at the falling edge and returns every strobe to zero after each operation. Most page codes are kept in range, but invalid codes, over-range nibble pairs and several-strobes-at-once cycles are mixed in deliberately, so that the clamp and priority paths are exercised.

// File: rtl/dispram_pkg.sv
`timescale 1ns/1ps
package dispram_pkg;

  // One-hot (or empty) action selected by the control for this cycle
  typedef struct packed {
    logic loadPage;
    logic loadColHi;
    logic loadColLo;
    logic doWrite;
    logic doRead;
  } ctrlStb_t;

endpackage

// File: rtl/dispram_ctrl.sv
`timescale 1ns/1ps
module dispram_ctrl
  import dispram_pkg::*;
#(
  parameter int PAGE_COUNT = 9,
  parameter int PAGE_W     = 4
) (
  input  logic              setPageStb,
  input  logic [PAGE_W-1:0] pageIn,
  input  logic              setColHiStb,
  input  logic              setColLoStb,
  input  logic              wrStb,
  input  logic              rdStb,
  output ctrlStb_t          stb
);

  localparam logic [PAGE_W-1:0] LAST_PAGE = PAGE_W'(PAGE_COUNT - 1);

  logic pageValid;
  assign pageValid = (pageIn <= LAST_PAGE);

  // Fixed priority; an out-of-range page code still consumes the cycle
  always_comb begin
    stb = '0;
    if (setPageStb)       stb.loadPage  = pageValid;
    else if (setColHiStb) stb.loadColHi = 1'b1;
    else if (setColLoStb) stb.loadColLo = 1'b1;
    else if (wrStb)       stb.doWrite   = 1'b1;
    else if (rdStb)       stb.doRead    = 1'b1;
  end

endmodule

// File: rtl/dispram_datapath.sv
`timescale 1ns/1ps
module dispram_datapath
  import dispram_pkg::*;
#(
  parameter int COL_COUNT      = 132,
  parameter int DATA_W         = 8,
  parameter int PAGE_COUNT     = 9,
  parameter int LAST_PAGE_BITS = 1,
  parameter int COL_W          = 8,
  parameter int PAGE_W         = 4,
  parameter int NIB_W          = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStb_t          stb,
  input  logic [PAGE_W-1:0] pageIn,
  input  logic [NIB_W-1:0]  nibbleIn,
  input  logic [DATA_W-1:0] hostDataIn,
  input  logic              adcRev,
  input  logic [DATA_W-1:0] ramRdData,
  output logic [PAGE_W-1:0] ramPage,
  output logic [COL_W-1:0]  ramCol,
  output logic              ramWrEn,
  output logic [DATA_W-1:0] ramWrData,
  output logic [DATA_W-1:0] rdData,
  output logic [COL_W-1:0]  segIdx
);

  localparam logic [COL_W-1:0]  COL_MAX   = COL_W'(COL_COUNT - 1);
  localparam logic [PAGE_W-1:0] LAST_PAGE = PAGE_W'(PAGE_COUNT - 1);

  logic [PAGE_W-1:0] curPage;
  logic [COL_W-1:0]  curCol;
  logic [DATA_W-1:0] holdReg;
  logic [DATA_W-1:0] rdReg;
  logic [DATA_W-1:0] pageMask;
  logic              onLastPage;
  logic [COL_W-1:0]  colAfterAccess;
  logic [COL_W-1:0]  colHiMerged;
  logic [COL_W-1:0]  colLoMerged;

  function automatic logic [COL_W-1:0] clampCol(input logic [COL_W-1:0] v);
    return (v > COL_MAX) ? COL_MAX : v;
  endfunction

  assign onLastPage = (curPage == LAST_PAGE);

  // Only the low bits exist on the partial last page
  for (genvar b = 0; b < DATA_W; b++) begin : g_mask
    if (b < LAST_PAGE_BITS) begin : g_keep
      assign pageMask[b] = 1'b1;
    end else begin : g_drop
      assign pageMask[b] = ~onLastPage;
    end
  end

  assign colAfterAccess = (curCol == COL_MAX) ? curCol : curCol + 1'b1;
  assign colHiMerged    = clampCol({nibbleIn, curCol[NIB_W-1:0]});
  assign colLoMerged    = clampCol({curCol[COL_W-1:NIB_W], nibbleIn});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curPage <= '0;
      curCol  <= '0;
      holdReg <= '0;
      rdReg   <= '0;
    end else begin
      if (stb.loadPage) curPage <= pageIn;
      if (stb.loadColHi)                  curCol <= colHiMerged;
      else if (stb.loadColLo)             curCol <= colLoMerged;
      else if (stb.doWrite || stb.doRead) curCol <= colAfterAccess;
      if (stb.doRead) begin
        rdReg   <= holdReg;
        holdReg <= ramRdData & pageMask;
      end
    end
  end

  assign ramPage   = curPage;
  assign ramCol    = curCol;
  assign ramWrEn   = stb.doWrite;
  assign ramWrData = hostDataIn & pageMask;
  assign rdData    = rdReg;
  assign segIdx    = adcRev ? (COL_MAX - curCol) : curCol;

endmodule

// File: rtl/dispram_access.sv
`timescale 1ns/1ps
module dispram_access
  import dispram_pkg::*;
#(
  parameter int COL_COUNT      = 132,
  parameter int DATA_W         = 8,
  parameter int PAGE_COUNT     = 9,
  parameter int LAST_PAGE_BITS = 1,
  localparam int COL_W  = $clog2(COL_COUNT),
  localparam int PAGE_W = $clog2(PAGE_COUNT),
  localparam int NIB_W  = COL_W / 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              setPageStb,
  input  logic [PAGE_W-1:0] pageIn,
  input  logic              setColHiStb,
  input  logic              setColLoStb,
  input  logic [NIB_W-1:0]  nibbleIn,
  input  logic              wrStb,
  input  logic              rdStb,
  input  logic [DATA_W-1:0] hostDataIn,
  input  logic              adcRev,
  output logic [PAGE_W-1:0] ramPage,
  output logic [COL_W-1:0]  ramCol,
  output logic              ramWrEn,
  output logic [DATA_W-1:0] ramWrData,
  input  logic [DATA_W-1:0] ramRdData,
  output logic [DATA_W-1:0] rdData,
  output logic [COL_W-1:0]  segIdx
);

  ctrlStb_t stb;

  dispram_ctrl #(
    .PAGE_COUNT(PAGE_COUNT),
    .PAGE_W    (PAGE_W)
  ) u_ctrl (
    .setPageStb (setPageStb),
    .pageIn     (pageIn),
    .setColHiStb(setColHiStb),
    .setColLoStb(setColLoStb),
    .wrStb      (wrStb),
    .rdStb      (rdStb),
    .stb        (stb)
  );

  dispram_datapath #(
    .COL_COUNT     (COL_COUNT),
    .DATA_W        (DATA_W),
    .PAGE_COUNT    (PAGE_COUNT),
    .LAST_PAGE_BITS(LAST_PAGE_BITS),
    .COL_W         (COL_W),
    .PAGE_W        (PAGE_W),
    .NIB_W         (NIB_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .pageIn    (pageIn),
    .nibbleIn  (nibbleIn),
    .hostDataIn(hostDataIn),
    .adcRev    (adcRev),
    .ramRdData (ramRdData),
    .ramPage   (ramPage),
    .ramCol    (ramCol),
    .ramWrEn   (ramWrEn),
    .ramWrData (ramWrData),
    .rdData    (rdData),
    .segIdx    (segIdx)
  );

endmodule

// File: rtl/dispram_access_chk.sv
`timescale 1ns/1ps
module dispram_access_chk #(
  parameter int COL_COUNT      = 132,
  parameter int DATA_W         = 8,
  parameter int PAGE_COUNT     = 9,
  parameter int LAST_PAGE_BITS = 1,
  localparam int COL_W  = $clog2(COL_COUNT),
  localparam int PAGE_W = $clog2(PAGE_COUNT)
) (
  input logic              clk,
  input logic              rstN,
  input logic              setPageStb,
  input logic [PAGE_W-1:0] pageIn,
  input logic              setColHiStb,
  input logic              setColLoStb,
  input logic              wrStb,
  input logic              rdStb,
  input logic              adcRev,
  input logic [PAGE_W-1:0] ramPage,
  input logic [COL_W-1:0]  ramCol,
  input logic              ramWrEn,
  input logic [DATA_W-1:0] ramWrData,
  input logic [DATA_W-1:0] rdData,
  input logic [COL_W-1:0]  segIdx
);

  localparam logic [COL_W-1:0]  COL_MAX   = COL_W'(COL_COUNT - 1);
  localparam logic [PAGE_W-1:0] LAST_PAGE = PAGE_W'(PAGE_COUNT - 1);

  logic anyLoad;
  logic onlyWrite;
  logic onlyRead;
  assign anyLoad   = setPageStb | setColHiStb | setColLoStb;
  assign onlyWrite = wrStb & ~anyLoad;
  assign onlyRead  = rdStb & ~anyLoad & ~wrStb;

  // R2
  page_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!setPageStb || pageIn > LAST_PAGE) |=> $stable(ramPage));

  // R3
  col_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    ramCol <= COL_MAX);

  // R4
  write_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    onlyWrite |-> ramWrEn);

  // R4
  write_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    (onlyWrite && ramCol != COL_MAX) |=> ramCol == $past(ramCol) + 1'b1);

  // R6
  rd_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !onlyRead |=> $stable(rdData));

  // R7
  col_saturate_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((onlyWrite || onlyRead) && ramCol == COL_MAX) |=> ramCol == COL_MAX);

  // R8
  last_page_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ramWrEn && ramPage == LAST_PAGE) |-> (ramWrData >> LAST_PAGE_BITS) == '0);

  // R9
  seg_reverse_chk: assert property (@(posedge clk) disable iff (!rstN)
    adcRev |-> (COL_W'(segIdx + ramCol) == COL_MAX));

  // R10
  write_priority_chk: assert property (@(posedge clk) disable iff (!rstN)
    ramWrEn |-> (wrStb && !anyLoad));

endmodule

bind dispram_access dispram_access_chk #(
  .COL_COUNT     (COL_COUNT),
  .DATA_W        (DATA_W),
  .PAGE_COUNT    (PAGE_COUNT),
  .LAST_PAGE_BITS(LAST_PAGE_BITS)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .setPageStb (setPageStb),
  .pageIn     (pageIn),
  .setColHiStb(setColHiStb),
  .setColLoStb(setColLoStb),
  .wrStb      (wrStb),
  .rdStb      (rdStb),
  .adcRev     (adcRev),
  .ramPage    (ramPage),
  .ramCol     (ramCol),
  .ramWrEn    (ramWrEn),
  .ramWrData  (ramWrData),
  .rdData     (rdData),
  .segIdx     (segIdx)
);

// File: tb/dispram_access_bench.sv
`timescale 1ns/1ps
module dispram_access_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       setPageStb = 1'b0;
  logic [3:0] pageIn = '0;
  logic       setColHiStb = 1'b0;
  logic       setColLoStb = 1'b0;
  logic [3:0] nibbleIn = '0;
  logic       wrStb = 1'b0;
  logic       rdStb = 1'b0;
  logic [7:0] hostDataIn = '0;
  logic       adcRev = 1'b0;
  logic [3:0] ramPage;
  logic [7:0] ramCol;
  logic       ramWrEn;
  logic [7:0] ramWrData;
  logic [7:0] ramRdData;
  logic [7:0] rdData;
  logic [7:0] segIdx;

  always #2.5 clk = ~clk;

  dispram_access u_dispram_access (
    .clk(clk), .rstN(rstN), .setPageStb(setPageStb), .pageIn(pageIn),
    .setColHiStb(setColHiStb), .setColLoStb(setColLoStb), .nibbleIn(nibbleIn),
    .wrStb(wrStb), .rdStb(rdStb), .hostDataIn(hostDataIn), .adcRev(adcRev),
    .ramPage(ramPage), .ramCol(ramCol), .ramWrEn(ramWrEn), .ramWrData(ramWrData),
    .ramRdData(ramRdData), .rdData(rdData), .segIdx(segIdx)
  );

  // Memory model (raw bytes) and reference contents (as the host should see them)
  logic [7:0] ramMem [0:8][0:131];
  logic [7:0] refMem [0:8][0:131];

  always_comb begin
    if (int'(ramPage) <= 8 && int'(ramCol) <= 131)
      ramRdData = ramMem[int'(ramPage)][int'(ramCol)];
    else
      ramRdData = 8'h00;
  end

  int nChecks = 0;
  int nErr    = 0;
  int expPage = 0;
  int expCol  = 0;
  logic [7:0] expHold = '0;
  logic [7:0] expRd   = '0;
  bit lastWasSetOrWrite = 1'b1;

  function automatic logic [7:0] maskFor(input int p);
    return (p == 8) ? 8'h01 : 8'hFF;
  endfunction

  function automatic int bumpCol(input int c);
    return (c >= 131) ? 131 : c + 1;
  endfunction

  function automatic int clampCol(input int c);
    return (c > 131) ? 131 : c;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // One operation: drive at a falling edge, check combinational outputs,
  // let one rising edge pass, then check the registered state.
  task automatic doOp(input bit sp, input logic [3:0] pg, input bit sh, input bit sl,
                      input logic [3:0] nib, input bit wr, input bit rd,
                      input logic [7:0] din, input bit adc);
    int act;
    bit wPend;
    int wp, wc;
    logic [7:0] wd;
    int colBefore;
    setPageStb = sp; pageIn = pg; setColHiStb = sh; setColLoStb = sl;
    nibbleIn = nib; wrStb = wr; rdStb = rd; hostDataIn = din; adcRev = adc;
    // R10 priority: 1 page, 2 hi, 3 lo, 4 write, 5 read, 0 none
    act = sp ? 1 : sh ? 2 : sl ? 3 : wr ? 4 : rd ? 5 : 0;
    #1;
    chk(ramWrEn == (act == 4), "R10 write enable vs priority", int'(ramWrEn), int'(act == 4));
    chk(int'(segIdx) == (adc ? 131 - expCol : expCol), "R9 segment index",
        int'(segIdx), adc ? 131 - expCol : expCol);
    wPend = ramWrEn;
    wp = int'(ramPage); wc = int'(ramCol); wd = ramWrData;
    if (act == 4) begin
      chk(int'(ramPage) == expPage && int'(ramCol) == expCol, "R4 write address",
          int'(ramPage) * 256 + int'(ramCol), expPage * 256 + expCol);
      chk(ramWrData == (din & maskFor(expPage)), "R8 write data mask",
          int'(ramWrData), int'(din & maskFor(expPage)));
    end
    @(posedge clk);
    if (wPend && wp <= 8 && wc <= 131) ramMem[wp][wc] = wd;
    @(negedge clk);
    colBefore = expCol;
    case (act)
      1: if (int'(pg) <= 8) expPage = int'(pg);
      2: expCol = clampCol(int'(nib) * 16 + (expCol % 16));
      3: expCol = clampCol((expCol / 16) * 16 + int'(nib));
      4: begin
           refMem[expPage][expCol] = din & maskFor(expPage);
           expCol = bumpCol(expCol);
         end
      5: begin
           expRd   = expHold;
           expHold = refMem[expPage][expCol] & maskFor(expPage);
           expCol  = bumpCol(expCol);
         end
      default: ;
    endcase
    chk(int'(ramPage) == expPage, "R2 page register", int'(ramPage), expPage);
    if (colBefore == 131 && (act == 4 || act == 5))
      chk(int'(ramCol) == 131, "R7 column saturation", int'(ramCol), 131);
    else if (act == 2 || act == 3)
      chk(int'(ramCol) == expCol, "R3 column load", int'(ramCol), expCol);
    else
      chk(int'(ramCol) == expCol, "R5 column advance", int'(ramCol), expCol);
    if (act == 5 && lastWasSetOrWrite)
      chk(rdData == expRd, "R6 dummy read returns held value", int'(rdData), int'(expRd));
    else
      chk(rdData == expRd, "R5 read data", int'(rdData), int'(expRd));
    if (act != 0) lastWasSetOrWrite = (act != 5);
    setPageStb = 1'b0; setColHiStb = 1'b0; setColLoStb = 1'b0;
    wrStb = 1'b0; rdStb = 1'b0;
  endtask

  task automatic setPage(input logic [3:0] p);
    doOp(1'b1, p, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 8'h00, 1'b0);
  endtask
  task automatic setCol(input logic [7:0] c);
    doOp(1'b0, 4'h0, 1'b1, 1'b0, c[7:4], 1'b0, 1'b0, 8'h00, 1'b0);
    doOp(1'b0, 4'h0, 1'b0, 1'b1, c[3:0], 1'b0, 1'b0, 8'h00, 1'b0);
  endtask
  task automatic wrByte(input logic [7:0] d);
    doOp(1'b0, 4'h0, 1'b0, 1'b0, 4'h0, 1'b1, 1'b0, d, 1'b0);
  endtask
  task automatic rdByte();
    doOp(1'b0, 4'h0, 1'b0, 1'b0, 4'h0, 1'b0, 1'b1, 8'h00, 1'b0);
  endtask

  initial begin
    #(5.0 * 190000);
    nChecks++;
    nErr++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int p = 0; p <= 8; p++)
      for (int c = 0; c <= 131; c++) begin
        ramMem[p][c] = 8'($urandom);
        refMem[p][c] = ramMem[p][c];
      end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(ramPage == 4'd0, "R1 reset page", int'(ramPage), 0);
    chk(ramCol == 8'd0, "R1 reset column", int'(ramCol), 0);
    chk(rdData == 8'd0, "R1 reset read data", int'(rdData), 0);
    chk(ramWrEn == 1'b0, "R1 reset write enable", int'(ramWrEn), 0);
    // R1 holder is zero: the first read returns 0
    rdByte();
    chk(rdData == 8'h00, "R1 reset holder", int'(rdData), 0);

    // R4 R5 R6: write two bytes, re-address, dummy read, real read
    setPage(4'd2);
    setCol(8'h10);
    wrByte(8'hA5);
    wrByte(8'h3C);
    setCol(8'h10);
    rdByte();
    rdByte();
    chk(rdData == 8'hA5, "R5 read after dummy", int'(rdData), 8'hA5);
    rdByte();
    chk(rdData == 8'h3C, "R5 second sequential read", int'(rdData), 8'h3C);

    // R7 saturation at the last column; page untouched
    setCol(8'h82);
    wrByte(8'h11);
    wrByte(8'h22);
    wrByte(8'h33);
    chk(ramCol == 8'h83, "R7 column stays at 83h", int'(ramCol), 8'h83);
    chk(ramPage == 4'd2, "R7 no carry into page", int'(ramPage), 2);

    // R3 clamp of over-range nibble values
    doOp(1'b0, 4'h0, 1'b1, 1'b0, 4'h9, 1'b0, 1'b0, 8'h00, 1'b0);
    chk(ramCol == 8'h83, "R3 high nibble clamp", int'(ramCol), 8'h83);
    setCol(8'h80);
    doOp(1'b0, 4'h0, 1'b0, 1'b1, 4'hF, 1'b0, 1'b0, 8'h00, 1'b0);
    chk(ramCol == 8'h83, "R3 low nibble clamp", int'(ramCol), 8'h83);

    // R2 invalid page code
    setPage(4'd12);
    chk(ramPage == 4'd2, "R2 invalid page ignored", int'(ramPage), 2);

    // R8 partial last page
    setPage(4'd8);
    setCol(8'h05);
    wrByte(8'hFF);
    ramMem[8][6] = 8'hFE;
    setCol(8'h05);
    rdByte();
    rdByte();
    chk(rdData == 8'h01, "R8 page 8 read masked", int'(rdData), 1);
    rdByte();
    chk(rdData == 8'h00, "R8 page 8 upper bits ignored", int'(rdData), 0);

    // R10 priority with overlapping strobes
    doOp(1'b1, 4'd3, 1'b1, 1'b1, 4'h2, 1'b1, 1'b1, 8'h77, 1'b0);
    chk(ramPage == 4'd3, "R10 page set wins", int'(ramPage), 3);
    doOp(1'b1, 4'd15, 1'b1, 1'b0, 4'h1, 1'b1, 1'b0, 8'h77, 1'b0);
    chk(ramPage == 4'd3, "R10 invalid page still blocks", int'(ramPage), 3);
    doOp(1'b0, 4'd0, 1'b1, 1'b1, 4'h4, 1'b0, 1'b0, 8'h00, 1'b0);
    doOp(1'b0, 4'd0, 1'b0, 1'b0, 4'h0, 1'b1, 1'b1, 8'h5A, 1'b0);

    // R9 direction at the column extremes
    setCol(8'h00);
    doOp(1'b0, 4'h0, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 8'h00, 1'b1);
    setCol(8'h83);
    doOp(1'b0, 4'h0, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 8'h00, 1'b1);

    // Constrained random mix
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 6)
        doOp(1'b1, ($urandom_range(0, 9) == 0) ? 4'($urandom_range(9, 15)) : 4'($urandom_range(0, 8)),
             1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 8'h00, 1'($urandom));
      else if (r < 12)
        doOp(1'b0, 4'h0, 1'b1, 1'b0, 4'($urandom_range(0, 9)), 1'b0, 1'b0, 8'h00, 1'($urandom));
      else if (r < 18)
        doOp(1'b0, 4'h0, 1'b0, 1'b1, 4'($urandom), 1'b0, 1'b0, 8'h00, 1'($urandom));
      else if (r < 55)
        doOp(1'b0, 4'h0, 1'b0, 1'b0, 4'h0, 1'b1, 1'b0, 8'($urandom), 1'($urandom));
      else if (r < 92)
        doOp(1'b0, 4'h0, 1'b0, 1'b0, 4'h0, 1'b0, 1'b1, 8'h00, 1'($urandom));
      else
        doOp(1'($urandom), 4'($urandom), 1'($urandom), 1'($urandom), 4'($urandom),
             1'($urandom), 1'($urandom), 8'($urandom), 1'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

endmodule